// File: doc/BRIEF.md
# Integer ALU with Three-way Compare

This block is the integer execution unit of a register-machine datapath. It is purely combinational: from an operation code and two operands it produces a single result word in the same cycle. The first operand always comes from a register. For the second operand, the caller either supplies a register value or raises a select input to pass an immediate instead. The immediate forms therefore behave exactly like the register forms.

The unit covers modular add, subtract and multiply, the three bitwise logic functions and three kinds of shift. It also provides two unary operations on the first operand: bit inversion and a logical NOT that yields a boolean. Comparisons write a numeric result rather than setting flags. A signed or unsigned three-way compare returns all ones (minus one) when the first operand is smaller, zero when the operands are equal, and one when the first operand is larger.

The word width is a parameter. Two further parameters choose the implementation of the multiplier (the language operator or an unrolled partial-product sum) and of the shifter (operator or staged barrel).

Top module: `int_alu_core`

## Requirements
- R1: Code 0 yields a+b and code 1 yields a−b, both keeping only the low DATA_W bits (wrap around).
- R2: Code 2 yields the low DATA_W bits of the full product a×b.
- R3: Codes 3, 4 and 5 yield bitwise AND, OR and XOR of a and b.
- R4: Code 6 shifts a left and code 7 shifts a right, both filling with zeros. The shift amount is the low log2(DATA_W) bits of b, and the higher bits of b are ignored.
- R5: Code 8 shifts a right by the same amount and fills with copies of a's top bit.
- R6: Code 9 compares a and b as two's-complement numbers and returns all ones if a<b, 0 if a==b and 1 if a>b.
- R7: Code 10 performs the same three-way compare with a and b taken as unsigned.
- R8: Code 11 yields a with every bit inverted; b has no effect.
- R9: Code 12 yields 1 when a is zero and 0 otherwise; b has no effect.
- R10: When use_imm_i is 1, imm_i takes the place of b_reg_i as operand b; when it is 0, imm_i has no effect.
- R11: Codes 13 to 15 yield a result of all zeros.
- R12: The alternative multiplier and shifter variants give the same results as the default variants at any width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| a_i | input | DATA_W | First operand (register value) |
| b_reg_i | input | DATA_W | Second operand when no immediate is selected |
| imm_i | input | DATA_W | Immediate second operand |
| use_imm_i | input | 1 | Selects imm_i as the second operand |
| result_o | output | DATA_W | Operation result |

## Verification
The bench builds two copies of the block. The first uses the default 64-bit width with the operator multiplier and operator shifter; it walks a vector table that covers wrap-around, sign boundaries and shift amounts with high bits set. The second uses a 16-bit width with the partial-product multiplier and the staged barrel shifter. At that width, product overflow, shift-amount truncation to four bits and the most-negative signed compare are easy to reach with small literals, so the alternative variants are exercised at their own boundaries.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_MUL  = 4'd2,
      OP_AND  = 4'd3,
      OP_OR   = 4'd4,
      OP_XOR  = 4'd5,
      OP_SHL  = 4'd6,
      OP_SHR  = 4'd7,
      OP_SRA  = 4'd8,
      OP_CMPS = 4'd9,
      OP_CMPU = 4'd10,
      OP_INV  = 4'd11,
      OP_LNOT = 4'd12
   } alu_op_e;

   typedef enum logic [1:0] {
      SH_LEFT  = 2'd0,
      SH_LOGIC = 2'd1,
      SH_ARITH = 2'd2
   } shift_kind_e;

endpackage

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              sub_i,
   output logic [DATA_W-1:0] sum_o
);

   logic [DATA_W-1:0] b_eff;

   always_comb begin
      b_eff = sub_i ? ~b_i : b_i;
      sum_o = a_i + b_eff + {{(DATA_W-1){1'b0}}, sub_i};
   end

   // R1: the sum minus (or plus) b restores a, modulo 2^DATA_W
   always_comb begin
      if (!$isunknown({a_i, b_i, sub_i, sum_o})) begin
         if (!sub_i)
            assert_add_inverse_R1: assert (sum_o - b_i == a_i);
         else
            assert_sub_inverse_R1: assert (sum_o + b_i == a_i);
      end
   end

endmodule

// File: rtl/int_alu_mul.sv
module int_alu_mul #(
   parameter int DATA_W   = 64,
   parameter int MUL_IMPL = 0
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] prod_o
);

   generate
      if (MUL_IMPL == 0) begin : g_op
         always_comb prod_o = a_i * b_i;
      end else begin : g_pp
         logic [DATA_W-1:0] pp [DATA_W];
         for (genvar i = 0; i < DATA_W; i++) begin : g_row
            assign pp[i] = b_i[i] ? (a_i << i) : '0;
         end
         always_comb begin
            prod_o = '0;
            for (int k = 0; k < DATA_W; k++) prod_o = prod_o + pp[k];
         end
      end
   endgenerate

   // R2: multiplying by zero or one is the identity on the low bits
   always_comb begin
      if (!$isunknown({a_i, b_i, prod_o})) begin
         if (b_i == '0)
            assert_mul_zero_R2: assert (prod_o == '0);
         if (b_i == {{(DATA_W-1){1'b0}}, 1'b1})
            assert_mul_one_R2: assert (prod_o == a_i);
      end
   end

endmodule

// File: rtl/int_alu_shift.sv
module int_alu_shift
   import int_alu_pkg::*;
#(
   parameter int DATA_W       = 64,
   parameter int SHIFT_STAGED = 0,
   localparam int SH_W        = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [SH_W-1:0]   amt_i,
   input  shift_kind_e       kind_i,
   output logic [DATA_W-1:0] res_o
);

   logic [DATA_W-1:0] shl, shr, sra;

   generate
      if (SHIFT_STAGED == 0) begin : g_op
         always_comb begin
            shl = a_i << amt_i;
            shr = a_i >> amt_i;
            sra = DATA_W'($signed(a_i) >>> amt_i);
         end
      end else begin : g_barrel
         logic [DATA_W-1:0] stl [SH_W+1];
         logic [DATA_W-1:0] str [SH_W+1];
         logic [DATA_W-1:0] sta [SH_W+1];
         assign stl[0] = a_i;
         assign str[0] = a_i;
         assign sta[0] = a_i;
         for (genvar s = 0; s < SH_W; s++) begin : g_stage
            assign stl[s+1] = amt_i[s] ? (stl[s] << (2**s)) : stl[s];
            assign str[s+1] = amt_i[s] ? (str[s] >> (2**s)) : str[s];
            assign sta[s+1] = amt_i[s] ? DATA_W'($signed(sta[s]) >>> (2**s)) : sta[s];
         end
         always_comb begin
            shl = stl[SH_W];
            shr = str[SH_W];
            sra = sta[SH_W];
         end
      end
   endgenerate

   always_comb begin
      unique case (kind_i)
         SH_LEFT:  res_o = shl;
         SH_LOGIC: res_o = shr;
         SH_ARITH: res_o = sra;
         default:  res_o = '0;
      endcase
   end

   // R4: a zero amount passes the operand unchanged
   // R5: arithmetic shift keeps the top bit
   always_comb begin
      if (!$isunknown({a_i, amt_i, kind_i, res_o})) begin
         if (amt_i == '0 && kind_i != SH_ARITH)
            assert_shift_zero_R4: assert (res_o == a_i);
         if (kind_i == SH_ARITH)
            assert_sra_sign_R5: assert (res_o[DATA_W-1] == a_i[DATA_W-1]);
      end
   end

endmodule

// File: rtl/int_alu_cmp.sv
module int_alu_cmp #(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              signed_i,
   output logic [DATA_W-1:0] res_o
);

   logic [DATA_W+1:0] a_x, b_x, diff;
   logic              less, equal;

   always_comb begin
      a_x   = {{2{signed_i & a_i[DATA_W-1]}}, a_i};
      b_x   = {{2{signed_i & b_i[DATA_W-1]}}, b_i};
      diff  = a_x - b_x;
      less  = diff[DATA_W+1];
      equal = (a_i == b_i);
      if (less)       res_o = '1;
      else if (equal) res_o = '0;
      else            res_o = {{(DATA_W-1){1'b0}}, 1'b1};
   end

   // R6, R7: result is one of the three encodings
   always_comb begin
      if (!$isunknown({a_i, b_i, signed_i, res_o})) begin
         assert_cmp_code_R6: assert (res_o == '1 || res_o == '0 ||
                                     res_o == {{(DATA_W-1){1'b0}}, 1'b1});
         if (!signed_i && b_i == '0)
            assert_cmpu_floor_R7: assert (res_o != '1);
      end
   end

endmodule

// File: rtl/int_alu_core.sv
module int_alu_core
   import int_alu_pkg::*;
#(
   parameter int DATA_W       = 64,
   parameter int MUL_IMPL     = 0,
   parameter int SHIFT_STAGED = 0,
   localparam int SH_W        = $clog2(DATA_W)
) (
   input  logic [3:0]        op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_reg_i,
   input  logic [DATA_W-1:0] imm_i,
   input  logic              use_imm_i,
   output logic [DATA_W-1:0] result_o
);

   generate
      if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("int_alu_core: DATA_W must be a power of two of at least 8");
      end
      if (MUL_IMPL < 0 || MUL_IMPL > 1) begin : g_bad_mul
         $error("int_alu_core: MUL_IMPL must be 0 or 1");
      end
      if (SHIFT_STAGED < 0 || SHIFT_STAGED > 1) begin : g_bad_shift
         $error("int_alu_core: SHIFT_STAGED must be 0 or 1");
      end
   endgenerate

   alu_op_e           op;
   logic [DATA_W-1:0] b_op;
   logic [DATA_W-1:0] sum_r, prod_r, shift_r, cmp_r;
   shift_kind_e       sh_kind;

   always_comb begin
      op   = alu_op_e'(op_i);
      b_op = use_imm_i ? imm_i : b_reg_i;
      case (op)
         OP_SHR:  sh_kind = SH_LOGIC;
         OP_SRA:  sh_kind = SH_ARITH;
         default: sh_kind = SH_LEFT;
      endcase
   end

   int_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
      .a_i   (a_i),
      .b_i   (b_op),
      .sub_i (op == OP_SUB),
      .sum_o (sum_r)
   );

   int_alu_mul #(.DATA_W(DATA_W), .MUL_IMPL(MUL_IMPL)) u_mul (
      .a_i    (a_i),
      .b_i    (b_op),
      .prod_o (prod_r)
   );

   int_alu_shift #(.DATA_W(DATA_W), .SHIFT_STAGED(SHIFT_STAGED)) u_shift (
      .a_i    (a_i),
      .amt_i  (b_op[SH_W-1:0]),
      .kind_i (sh_kind),
      .res_o  (shift_r)
   );

   int_alu_cmp #(.DATA_W(DATA_W)) u_cmp (
      .a_i      (a_i),
      .b_i      (b_op),
      .signed_i (op == OP_CMPS),
      .res_o    (cmp_r)
   );

   always_comb begin
      case (op)
         OP_ADD, OP_SUB:          result_o = sum_r;
         OP_MUL:                  result_o = prod_r;
         OP_AND:                  result_o = a_i & b_op;
         OP_OR:                   result_o = a_i | b_op;
         OP_XOR:                  result_o = a_i ^ b_op;
         OP_SHL, OP_SHR, OP_SRA:  result_o = shift_r;
         OP_CMPS, OP_CMPU:        result_o = cmp_r;
         OP_INV:                  result_o = ~a_i;
         OP_LNOT:                 result_o = {{(DATA_W-1){1'b0}}, (a_i == '0)};
         default:                 result_o = '0;
      endcase
   end

   always_comb begin
      if (!$isunknown({op_i, a_i, b_op, result_o})) begin
         // R8: inversion result and operand share no set bit and cover all bits
         if (op_i == 4'd11)
            assert_inv_cover_R8: assert ((result_o ^ a_i) == '1);
         // R9: logical NOT is boolean
         if (op_i == 4'd12)
            assert_lnot_bool_R9: assert ($countones(result_o) <= 1);
         // R11: spare codes produce zero
         if (op_i > 4'd12)
            assert_spare_zero_R11: assert (result_o == '0);
         // R3: AND never exceeds OR bitwise
         if (op_i == 4'd3)
            assert_and_subset_R3: assert ((result_o & ~(a_i | b_op)) == '0);
      end
   end

endmodule

// File: tb/int_alu_core_tb_top.sv
module int_alu_core_tb_top;

   localparam int W  = 64;
   localparam int WS = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic [3:0]    op;
   logic [W-1:0]  a, b, imm;
   logic          use_imm;
   logic [W-1:0]  res;

   logic [3:0]    op_s;
   logic [WS-1:0] a_s, b_s, imm_s;
   logic          use_imm_s;
   logic [WS-1:0] res_s;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   int_alu_core #(.DATA_W(W)) dut_i (
      .op_i(op), .a_i(a), .b_reg_i(b), .imm_i(imm), .use_imm_i(use_imm), .result_o(res)
   );

   int_alu_core #(.DATA_W(WS), .MUL_IMPL(1), .SHIFT_STAGED(1)) dut_alt_i (
      .op_i(op_s), .a_i(a_s), .b_reg_i(b_s), .imm_i(imm_s), .use_imm_i(use_imm_s), .result_o(res_s)
   );

   typedef struct packed {
      logic [3:0]   op;
      logic [63:0]  a;
      logic [63:0]  b;
      logic [63:0]  imm;
      logic         sel;
      logic [63:0]  exp;
      logic [7:0]   req;
   } vec_t;

   localparam int NV = 28;
   localparam vec_t VECS [NV] = '{
      // R1 wrap
      '{4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, 1'b0, 64'd0, 8'd1},
      '{4'd1, 64'd0, 64'd1, 64'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 8'd1},
      '{4'd0, 64'd1234, 64'd4321, 64'd0, 1'b0, 64'd5555, 8'd1},
      // R2 low product bits
      '{4'd2, 64'h1_0000_0000, 64'h1_0000_0000, 64'd0, 1'b0, 64'd0, 8'd2},
      '{4'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 64'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFD, 8'd2},
      '{4'd2, 64'd12345, 64'd1000, 64'd0, 1'b0, 64'd12345000, 8'd2},
      // R3 bitwise
      '{4'd3, 64'hF0F0_F0F0_FF00_FF00, 64'hFFFF_0000_0F0F_F0F0, 64'd0, 1'b0, 64'hF0F0_0000_0F00_F000, 8'd3},
      '{4'd4, 64'hF0F0_F0F0_FF00_FF00, 64'hFFFF_0000_0F0F_F0F0, 64'd0, 1'b0, 64'hFFFF_F0F0_FF0F_FFF0, 8'd3},
      '{4'd5, 64'hF0F0_F0F0_FF00_FF00, 64'hFFFF_0000_0F0F_F0F0, 64'd0, 1'b0, 64'h0F0F_F0F0_F00F_0FF0, 8'd3},
      // R4 logical shifts, amount truncated to 6 bits
      '{4'd6, 64'd1, 64'h43, 64'd0, 1'b0, 64'd8, 8'd4},
      '{4'd7, 64'h8000_0000_0000_0000, 64'd63, 64'd0, 1'b0, 64'd1, 8'd4},
      '{4'd7, 64'h8000_0000_0000_0000, 64'hFFC0, 64'd0, 1'b0, 64'h8000_0000_0000_0000, 8'd4},
      // R5 arithmetic shift
      '{4'd8, 64'h8000_0000_0000_0000, 64'd4, 64'd0, 1'b0, 64'hF800_0000_0000_0000, 8'd5},
      '{4'd8, 64'h4000_0000_0000_0000, 64'd1, 64'd0, 1'b0, 64'h2000_0000_0000_0000, 8'd5},
      // R6 signed compare
      '{4'd9, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 8'd6},
      '{4'd9, 64'd5, 64'hFFFF_FFFF_FFFF_FFFD, 64'd0, 1'b0, 64'd1, 8'd6},
      '{4'd9, 64'd77, 64'd77, 64'd0, 1'b0, 64'd0, 8'd6},
      // R7 unsigned compare
      '{4'd10, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, 1'b0, 64'd1, 8'd7},
      '{4'd10, 64'd2, 64'd9, 64'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 8'd7},
      '{4'd10, 64'hAB, 64'hAB, 64'd0, 1'b0, 64'd0, 8'd7},
      // R8 inversion, b ignored
      '{4'd11, 64'd0, 64'h1234, 64'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 8'd8},
      // R9 logical not, b ignored
      '{4'd12, 64'd0, 64'hFFFF, 64'd0, 1'b0, 64'd1, 8'd9},
      '{4'd12, 64'h8000_0000_0000_0000, 64'd0, 64'd0, 1'b0, 64'd0, 8'd9},
      // R10 operand select
      '{4'd0, 64'd1, 64'd5, 64'd7, 1'b1, 64'd8, 8'd10},
      '{4'd0, 64'd1, 64'd5, 64'd7, 1'b0, 64'd6, 8'd10},
      '{4'd9, 64'd3, 64'd1, 64'd9, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 8'd10},
      // R11 spare codes
      '{4'd13, 64'd5, 64'd5, 64'd0, 1'b0, 64'd0, 8'd11},
      '{4'd15, 64'hFFFF, 64'h1, 64'd0, 1'b0, 64'd0, 8'd11}
   };

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic run64(input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] y,
                        input logic [W-1:0] im, input logic s);
      @(negedge clk);
      op = o; a = x; b = y; imm = im; use_imm = s;
      #2;
   endtask

   task automatic run16(input logic [3:0] o, input logic [WS-1:0] x, input logic [WS-1:0] y,
                        input logic [WS-1:0] im, input logic s);
      @(negedge clk);
      op_s = o; a_s = x; b_s = y; imm_s = im; use_imm_s = s;
      #2;
   endtask

   task automatic c16(input string req, input logic [WS-1:0] exp);
      check(req, W'(res_s), W'(exp));
   endtask

   initial begin
      op = '0; a = '0; b = '0; imm = '0; use_imm = 1'b0;
      op_s = '0; a_s = '0; b_s = '0; imm_s = '0; use_imm_s = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // idle state after reset: add of zeros gives zero (R1)
      run64(4'd0, '0, '0, '0, 1'b0);
      check("R1 idle", res, '0);

      for (int i = 0; i < NV; i++) begin
         run64(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].imm, VECS[i].sel);
         check($sformatf("R%0d vec %0d", VECS[i].req, i), res, VECS[i].exp);
      end

      // R10: changing imm while unselected leaves result unchanged
      run64(4'd5, 64'hAA, 64'h0F, 64'hFFFF, 1'b0);
      check("R10 imm ignored", res, 64'hA5);

      // R12: alternative variants at 16 bits
      run16(4'd2, 16'h0100, 16'h0100, 16'h0, 1'b0);
      c16("R12 R2 mul wrap", 16'h0000);
      run16(4'd2, 16'h00FF, 16'h00FF, 16'h0, 1'b0);
      c16("R12 R2 mul", 16'hFE01);
      run16(4'd2, 16'h0003, 16'h0, 16'hFFFF, 1'b1);
      c16("R12 R10 mul imm", 16'hFFFD);
      run16(4'd6, 16'h0001, 16'h0013, 16'h0, 1'b0);
      c16("R12 R4 shl trunc", 16'h0008);
      run16(4'd7, 16'hF000, 16'h0004, 16'h0, 1'b0);
      c16("R12 R4 shr", 16'h0F00);
      run16(4'd8, 16'h8000, 16'h000F, 16'h0, 1'b0);
      c16("R12 R5 sra", 16'hFFFF);
      run16(4'd8, 16'h4000, 16'h0002, 16'h0, 1'b0);
      c16("R12 R5 sra pos", 16'h1000);
      run16(4'd9, 16'h8000, 16'h7FFF, 16'h0, 1'b0);
      c16("R12 R6 cmps min", 16'hFFFF);
      run16(4'd10, 16'h8000, 16'h7FFF, 16'h0, 1'b0);
      c16("R12 R7 cmpu", 16'h0001);
      run16(4'd1, 16'h0000, 16'h0001, 16'h0, 1'b0);
      c16("R12 R1 sub wrap", 16'hFFFF);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule